// File: doc/BRIEF.md
# Debug Access Authorization Gate

This block decides whether an external debug agent may reach a set of internal assets. It takes a software-writable shield bit, a boot-stage register, a privilege-qualified debug request and the result of an external password checker. From these it produces a debugger-enable level, one access grant per asset, an effective privilege level for the core, and a gated read path through which the debugger fetches asset data.

The shield bit resets to the locked value. Software can write it only after the boot ROM has handed control to user software, so the debugger stays locked from reset through ROM execution. Debug mode starts only through the enable flag that belongs to the current privilege level. Elevation to machine privilege needs debug mode and a passed password check together. Each asset carries a parameter-set access level. Assets at the full level are reachable only inside a fresh-session window, which closes as soon as user-level software has run after the handoff.

The authorization state machine has four states. ST_LOCKED means the shield is set. ST_IDLE means the shield is clear and no debug session is open. ST_DEBUG means debug mode is on and the password is not yet checked. ST_AUTH means debug mode is on and the password has been checked. The transitions are as follows. Any state goes to ST_LOCKED when the shield is or becomes set. ST_LOCKED goes to ST_IDLE when the shield becomes clear. ST_IDLE goes to ST_DEBUG on a request whose level flag is set. ST_DEBUG goes to ST_AUTH on a password pulse while the request is held. ST_DEBUG and ST_AUTH go back to ST_IDLE when the request drops.

Top module: `dbg_auth_gate`

## Requirements
- R1: After reset the shield is 1 (1 = debugger disabled, 0 = enabled): `dbg_enable` is 0, `asset_grant` is all zero and `eff_priv` equals `cur_priv`.
- R2: The boot stage starts at ROM and moves to user software on a cycle with `boot_handoff` high. While the stage is ROM, shield writes are ignored and the debugger stays disabled. After the handoff, a write of 0 sets `dbg_enable` to 1 from the next clock edge.
- R3: Privilege codes are user 2'b00, supervisor 2'b01, reserved 2'b10 and machine 2'b11. Debug mode is entered on `dbg_req` only when `cur_priv` is machine and `dbg_en_m` is 1, or when `cur_priv` is user and `dbg_en_u` is 1. The other privilege codes never enter debug mode.
- R4: `eff_priv` is 2'b11 only when debug mode is active and a `pwd_ok` pulse has been accepted during that session. A pulse outside debug mode is ignored. Debug mode alone, or a password alone, leaves `eff_priv` equal to `cur_priv`.
- R5: Asset levels are 2-bit codes: 0 none, 1 user, 2 full, and 3 is treated as none. A user-level asset is granted while debug mode is active. A full-level asset is granted only while the session is authorized and the fresh window is open. A none-level asset is never granted. The default configuration is asset 0 none, asset 1 user and asset 2 full.
- R6: The fresh window opens at reset. It closes for good once the stage is user software and `cur_priv` is user at a clock edge. After that, full-level assets stay denied even in an authorized session.
- R7: Dropping `dbg_req`, or writing 1 to the shield after the handoff, ends debug mode and discards the accepted password at the next clock edge. From that edge, grants are zero and `eff_priv` follows `cur_priv`.
- R8: A cycle with `acc_valid` high produces its result one cycle later. If the selected asset is granted, `acc_rdata` is that asset's data and `acc_violation` is 0. If the asset is denied or `acc_sel` is not below the asset count, `acc_rdata` is 0 and `acc_violation` is 1 for that one cycle. With no access, both outputs are 0.
- R9: A reset at any time ends the session, closes the grants, restores the shield to 1 and returns the stage to ROM, so later shield writes are ignored again until a new handoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_handoff | input | 1 | ROM has passed control to user software |
| shield_we | input | 1 | Software write strobe for the shield bit |
| shield_wdata | input | 1 | Shield value to write (1 locks) |
| dbg_req | input | 1 | Debug request from the external agent |
| cur_priv | input | 2 | Current core privilege level |
| dbg_en_m | input | 1 | Debug entry allowed at machine level |
| dbg_en_u | input | 1 | Debug entry allowed at user level |
| pwd_ok | input | 1 | Password-passed pulse from the checker |
| acc_valid | input | 1 | Debugger asset read request |
| acc_sel | input | SELW | Asset index of the read |
| asset_data | input | NASSET*DW | Packed asset contents, asset 0 in the low bits |
| dbg_enable | output | 1 | Debugger enabled (shield clear) |
| asset_grant | output | NASSET | Per-asset access grant |
| eff_priv | output | 2 | Effective privilege level |
| acc_rdata | output | DW | Read data, zero when denied |
| acc_violation | output | 1 | One-cycle flag for a rejected read |

## Verification
The main sweep walks every privilege code against all four settings of the two level flags, each with and without a password pulse. This separates the correct per-level entry from entry through the wrong flag, and shows that neither debug mode nor a password raises the privilege alone. A pulse sent before the request shows that early passwords are discarded. Machine and supervisor codes are tried before any user-level cycle and the user code after it, so the same authorized pattern shows the full-level asset granted inside the fresh window and denied after it. Separate patterns cover shield writes during ROM, revocation by a shield write, reads of none-level and out-of-range assets, and a reset in the middle of a session.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_R = 2'b10,
        PRIV_M = 2'b11
    } priv_t;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_USER = 2'd1,
        LVL_FULL = 2'd2,
        LVL_RSVD = 2'd3
    } lvl_t;

    typedef enum logic [1:0] {
        ST_LOCKED,
        ST_IDLE,
        ST_DEBUG,
        ST_AUTH
    } auth_st_t;

endpackage

// File: rtl/dbg_stage_shield.sv
module dbg_stage_shield
    import dbg_auth_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_handoff,
    input  logic       shield_we,
    input  logic       shield_wdata,
    input  logic [1:0] cur_priv,
    output logic       stage_user,
    output logic       shield_q,
    output logic       shield_nxt,
    output logic       fresh_q
);

    // Software writes land only once the ROM has handed over.
    assign shield_nxt = (shield_we && stage_user) ? shield_wdata : shield_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_user <= 1'b0;
            shield_q   <= 1'b1;
            fresh_q    <= 1'b1;
        end else begin
            if (boot_handoff)
                stage_user <= 1'b1;
            shield_q <= shield_nxt;
            // User code running after handoff may leave session data behind.
            if (stage_user && (cur_priv == PRIV_U))
                fresh_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_auth_fsm.sv
module dbg_auth_fsm
    import dbg_auth_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock,
    input  logic       dbg_req,
    input  logic [1:0] cur_priv,
    input  logic       dbg_en_m,
    input  logic       dbg_en_u,
    input  logic       pwd_ok,
    output logic       dbg_mode,
    output logic       pwd_pass
);

    auth_st_t state_q, state_d;
    logic     entry_ok;

    always_comb begin
        unique case (cur_priv)
            PRIV_M:  entry_ok = dbg_en_m;
            PRIV_U:  entry_ok = dbg_en_u;
            default: entry_ok = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (lock) begin
            state_d = ST_LOCKED;
        end else begin
            unique case (state_q)
                ST_LOCKED: state_d = ST_IDLE;
                ST_IDLE:   if (dbg_req && entry_ok) state_d = ST_DEBUG;
                ST_DEBUG:  if (!dbg_req)            state_d = ST_IDLE;
                           else if (pwd_ok)         state_d = ST_AUTH;
                ST_AUTH:   if (!dbg_req)            state_d = ST_IDLE;
                default:   state_d = ST_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOCKED;
        else
            state_q <= state_d;
    end

    always_comb begin
        dbg_mode = 1'b0;
        pwd_pass = 1'b0;
        unique case (state_q)
            ST_DEBUG: dbg_mode = 1'b1;
            ST_AUTH: begin
                dbg_mode = 1'b1;
                pwd_pass = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dbg_asset_port.sv
module dbg_asset_port #(
    parameter int                  NASSET    = 3,
    parameter int                  DW        = 8,
    parameter int                  SELW      = 2,
    parameter logic [2*NASSET-1:0] ASSET_LVL = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dbg_mode,
    input  logic                 pwd_pass,
    input  logic                 fresh,
    input  logic                 acc_valid,
    input  logic [SELW-1:0]      acc_sel,
    input  logic [NASSET*DW-1:0] asset_data,
    output logic [NASSET-1:0]    asset_grant,
    output logic [DW-1:0]        acc_rdata,
    output logic                 acc_violation
);

    localparam int SLOTS = 1 << SELW;

    logic [SLOTS-1:0] grant_pad;
    logic [DW-1:0]    data_arr [SLOTS];
    logic             hit;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NASSET) begin : g_asset
            localparam logic [1:0] LVL = ASSET_LVL[2*i +: 2];
            if (LVL == 2'd1) begin : g_user
                assign asset_grant[i] = dbg_mode;
            end else if (LVL == 2'd2) begin : g_full
                assign asset_grant[i] = pwd_pass && fresh;
            end else begin : g_none
                assign asset_grant[i] = 1'b0;
            end
            assign grant_pad[i] = asset_grant[i];
            assign data_arr[i]  = asset_data[DW*i +: DW];
        end else begin : g_pad
            assign grant_pad[i] = 1'b0;
            assign data_arr[i]  = '0;
        end
    end

    assign hit = grant_pad[acc_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_rdata     <= '0;
            acc_violation <= 1'b0;
        end else begin
            acc_rdata     <= (acc_valid && hit) ? data_arr[acc_sel] : '0;
            acc_violation <= acc_valid && !hit;
        end
    end

endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
    import dbg_auth_pkg::*;
#(
    parameter int                  NASSET    = 3,
    parameter int                  DW        = 8,
    parameter int                  SELW      = 2,
    parameter logic [2*NASSET-1:0] ASSET_LVL = 6'b10_01_00
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_handoff,
    input  logic                 shield_we,
    input  logic                 shield_wdata,
    input  logic                 dbg_req,
    input  logic [1:0]           cur_priv,
    input  logic                 dbg_en_m,
    input  logic                 dbg_en_u,
    input  logic                 pwd_ok,
    input  logic                 acc_valid,
    input  logic [SELW-1:0]      acc_sel,
    input  logic [NASSET*DW-1:0] asset_data,
    output logic                 dbg_enable,
    output logic [NASSET-1:0]    asset_grant,
    output logic [1:0]           eff_priv,
    output logic [DW-1:0]        acc_rdata,
    output logic                 acc_violation
);

    logic stage_user, shield_q, shield_nxt, fresh_q;
    logic dbg_mode, pwd_pass;

    dbg_stage_shield u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_handoff (boot_handoff),
        .shield_we    (shield_we),
        .shield_wdata (shield_wdata),
        .cur_priv     (cur_priv),
        .stage_user   (stage_user),
        .shield_q     (shield_q),
        .shield_nxt   (shield_nxt),
        .fresh_q      (fresh_q)
    );

    dbg_auth_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (shield_nxt),
        .dbg_req  (dbg_req),
        .cur_priv (cur_priv),
        .dbg_en_m (dbg_en_m),
        .dbg_en_u (dbg_en_u),
        .pwd_ok   (pwd_ok),
        .dbg_mode (dbg_mode),
        .pwd_pass (pwd_pass)
    );

    dbg_asset_port #(
        .NASSET    (NASSET),
        .DW        (DW),
        .SELW      (SELW),
        .ASSET_LVL (ASSET_LVL)
    ) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .dbg_mode      (dbg_mode),
        .pwd_pass      (pwd_pass),
        .fresh         (fresh_q),
        .acc_valid     (acc_valid),
        .acc_sel       (acc_sel),
        .asset_data    (asset_data),
        .asset_grant   (asset_grant),
        .acc_rdata     (acc_rdata),
        .acc_violation (acc_violation)
    );

    assign dbg_enable = !shield_q;
    // Elevation needs the open session and the accepted password together.
    assign eff_priv   = (dbg_mode && pwd_pass) ? PRIV_M : cur_priv;

endmodule

// File: rtl/dbg_auth_checker.sv
module dbg_auth_checker #(
    parameter int                  NASSET    = 3,
    parameter int                  DW        = 8,
    parameter logic [2*NASSET-1:0] ASSET_LVL = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stage_user,
    input logic              shield_we,
    input logic              shield_wdata,
    input logic              dbg_req,
    input logic [1:0]        cur_priv,
    input logic              acc_valid,
    input logic              dbg_enable,
    input logic [NASSET-1:0] asset_grant,
    input logic [1:0]        eff_priv,
    input logic [DW-1:0]     acc_rdata,
    input logic              acc_violation
);

    function automatic logic [NASSET-1:0] full_mask();
        logic [NASSET-1:0] m;
        for (int i = 0; i < NASSET; i++)
            m[i] = (ASSET_LVL[2*i +: 2] == 2'd2);
        return m;
    endfunction

    localparam logic [NASSET-1:0] FULL_M = full_mask();

    // R2: nothing is reachable during the ROM stage
    assert_rom_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_user |-> (!dbg_enable && asset_grant == '0));

    // R4: any change of privilege is an elevation to machine inside an enabled debugger
    assert_elev_machine_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_priv != cur_priv) |-> (eff_priv == 2'b11 && dbg_enable));

    // R5: a full-level grant only comes with machine privilege
    assert_full_needs_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((asset_grant & FULL_M) != '0) |-> (eff_priv == 2'b11));

    // R7: dropping the request revokes at the next edge
    assert_drop_revoke_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_req |=> (asset_grant == '0 && eff_priv == cur_priv));

    // R7: locking the shield revokes at the next edge
    assert_shield_revoke_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shield_we && shield_wdata && stage_user) |=> (!dbg_enable && asset_grant == '0));

    // R8: a violation never carries data
    assert_viol_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_violation |-> (acc_rdata == '0));

    // R8: no request, no flag in the following cycle
    assert_viol_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!acc_violation && acc_rdata == '0));

endmodule

bind dbg_auth_gate dbg_auth_checker #(
    .NASSET    (NASSET),
    .DW        (DW),
    .ASSET_LVL (ASSET_LVL)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stage_user    (stage_user),
    .shield_we     (shield_we),
    .shield_wdata  (shield_wdata),
    .dbg_req       (dbg_req),
    .cur_priv      (cur_priv),
    .acc_valid     (acc_valid),
    .dbg_enable    (dbg_enable),
    .asset_grant   (asset_grant),
    .eff_priv      (eff_priv),
    .acc_rdata     (acc_rdata),
    .acc_violation (acc_violation)
);

// File: tb/dbg_auth_gate_test.sv
`timescale 1ns/1ps
module dbg_auth_gate_test;

    localparam int NASSET = 3;
    localparam int DW     = 8;
    localparam int SELW   = 2;

    logic                 clk = 1'b0;
    logic                 rst_n, boot_handoff, shield_we, shield_wdata;
    logic                 dbg_req, dbg_en_m, dbg_en_u, pwd_ok, acc_valid;
    logic [1:0]           cur_priv;
    logic [SELW-1:0]      acc_sel;
    logic [NASSET*DW-1:0] asset_data;
    logic                 dbg_enable, acc_violation;
    logic [NASSET-1:0]    asset_grant;
    logic [1:0]           eff_priv;
    logic [DW-1:0]        acc_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dbg_auth_gate #(.NASSET(NASSET), .DW(DW), .SELW(SELW)) uut (
        .clk(clk), .rst_n(rst_n), .boot_handoff(boot_handoff),
        .shield_we(shield_we), .shield_wdata(shield_wdata),
        .dbg_req(dbg_req), .cur_priv(cur_priv), .dbg_en_m(dbg_en_m),
        .dbg_en_u(dbg_en_u), .pwd_ok(pwd_ok), .acc_valid(acc_valid),
        .acc_sel(acc_sel), .asset_data(asset_data),
        .dbg_enable(dbg_enable), .asset_grant(asset_grant),
        .eff_priv(eff_priv), .acc_rdata(acc_rdata),
        .acc_violation(acc_violation)
    );

    function automatic logic [DW-1:0] adata(input int i);
        return DW'(8'hA0 + i);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic fresh_m;
        for (int i = 0; i < NASSET; i++) asset_data[DW*i +: DW] = adata(i);
        rst_n = 0; boot_handoff = 0; shield_we = 0; shield_wdata = 0;
        dbg_req = 0; dbg_en_m = 0; dbg_en_u = 0; pwd_ok = 0;
        acc_valid = 0; acc_sel = '0; cur_priv = 2'b11;
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 enable", dbg_enable, 0);
        chk("R1 grant", asset_grant, 0);
        chk("R1 priv", eff_priv, 2'b11);

        // R2 write in ROM stage ignored
        shield_we = 1; shield_wdata = 0; tick(); shield_we = 0; tick();
        chk("R2 rom write", dbg_enable, 0);
        boot_handoff = 1; tick(); boot_handoff = 0;
        shield_we = 1; shield_wdata = 0; tick(); shield_we = 0;
        chk("R2 user write", dbg_enable, 1);

        // R3 R4 R5 R6 sweep: machine, supervisor, reserved, then user
        fresh_m = 1;
        for (int pi = 0; pi < 4; pi++) begin
            logic [1:0] p;
            p = (pi == 0) ? 2'b11 : (pi == 1) ? 2'b01 : (pi == 2) ? 2'b10 : 2'b00;
            for (int f = 0; f < 4; f++) begin
                for (int w = 0; w < 2; w++) begin
                    logic entered, auth, g2;
                    cur_priv = p; dbg_en_m = f[0]; dbg_en_u = f[1]; dbg_req = 0;
                    tick();
                    if (p == 2'b00) fresh_m = 0;
                    pwd_ok = 1; tick(); pwd_ok = 0;
                    chk("R4 early pwd ignored", eff_priv, p);
                    dbg_req = 1; tick();
                    entered = (p == 2'b11 && f[0]) || (p == 2'b00 && f[1]);
                    chk("R3 entry grant", asset_grant, {2'b00, entered, 1'b0});
                    chk("R4 debug alone", eff_priv, p);
                    auth = 0;
                    if (w == 1) begin
                        pwd_ok = 1; tick(); pwd_ok = 0;
                        auth = entered;
                    end
                    g2 = auth && fresh_m;
                    chk("R4 eff priv", eff_priv, auth ? 2'b11 : p);
                    chk("R5 R6 grants", asset_grant, {g2, entered, 1'b0});
                    acc_valid = 1; acc_sel = 2; tick(); acc_valid = 0;
                    chk("R8 full rdata", acc_rdata, g2 ? adata(2) : 0);
                    chk("R8 full viol", acc_violation, !g2);
                    dbg_req = 0; tick();
                    chk("R7 drop grant", asset_grant, 0);
                    chk("R7 drop priv", eff_priv, p);
                    chk("R8 viol one cycle", acc_violation, 0);
                end
            end
        end

        // R6 explicit: authorized machine session after window closed
        cur_priv = 2'b11; dbg_en_m = 1; dbg_req = 1; tick();
        pwd_ok = 1; tick(); pwd_ok = 0;
        chk("R6 auth priv", eff_priv, 2'b11);
        chk("R6 full denied", asset_grant, 3'b010);

        // R8 user asset read, none asset, out of range
        acc_valid = 1; acc_sel = 1; tick();
        chk("R8 user rdata", acc_rdata, adata(1));
        chk("R8 user viol", acc_violation, 0);
        acc_sel = 0; tick();
        chk("R8 none rdata", acc_rdata, 0);
        chk("R8 none viol", acc_violation, 1);
        acc_sel = 3; tick(); acc_valid = 0;
        chk("R8 range viol", acc_violation, 1);
        chk("R8 range rdata", acc_rdata, 0);

        // R7 shield write of 1 revokes
        shield_we = 1; shield_wdata = 1; tick(); shield_we = 0;
        chk("R7 shield enable", dbg_enable, 0);
        chk("R7 shield grant", asset_grant, 0);
        chk("R7 shield priv", eff_priv, 2'b11);
        cur_priv = 2'b00; #1;
        chk("R7 shield priv follows", eff_priv, 2'b00);

        // R9 reset mid-session
        shield_we = 1; shield_wdata = 0; tick(); shield_we = 0;
        cur_priv = 2'b00; dbg_en_u = 1; tick();
        chk("R9 pre reset grant", asset_grant, 3'b010);
        rst_n = 0; #1;
        chk("R9 reset grant", asset_grant, 0);
        chk("R9 reset enable", dbg_enable, 0);
        tick(); rst_n = 1; tick();
        shield_we = 1; shield_wdata = 0; tick(); shield_we = 0; tick();
        chk("R9 rom again", dbg_enable, 0);
        chk("R9 no grant", asset_grant, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule